// File: doc/BRIEF.md
# Machine Check Interruption Controller

This block collects hardware error conditions reported by the rest of a processor and decides when a machine check interruption is taken. The sources are a power warning from the supply, errors in the CPU timer or clock comparator, a faulty store of a timing facility, processor storage error reports with their failing address, and damage indications. Two of these, system damage and instruction processing damage, are exigent and are taken at once. The others are repressible. They are held pending until the PSW machine check mask and their own submask bit in a control register allow them.

When an interruption is accepted, the block does four things. It strobes the CPU timer and clock comparator snapshot requests. It merges every enabled pending condition into one 64-bit interruption code and issues a one-cycle taken pulse. It clears only the conditions it accepted. The code uses the architectural numbering, so code bit n appears on `code_o[63-n]`. The validity bits in the code are cleared selectively, depending on the damage type.

Top module: `mck_intr_ctrl`

## Requirements
- R1: A power warning event sets a pending warning. It is accepted only while `psw_mck_i` is 1 and `submask_i[7]` is 1. Otherwise it stays pending without limit.
- R2: An accepted warning sets code bits 7 and 8.
- R3: A CPU timer error, a clock comparator error or a faulty timing store sets a pending timing damage condition. It is accepted only while `psw_mck_i` and `submask_i[6]` are both 1, and it then sets code bit 3.
- R4: `snap_tmr_o` and `snap_cmp_o` are high in exactly the cycle before each `take_o` pulse. Code bit 46 copies `tmr_ok_i` and code bit 47 copies `cmp_ok_i`, both sampled in that strobe cycle.
- R5: Storage reports are gated by `psw_mck_i` and `submask_i[4]`. An uncorrected report sets bit 16, a corrected report sets bit 17 and a protection key report sets bit 18. Any of them also sets bit 2 and bit 24, and `fail_addr_o` then holds the address given with the latest report.
- R6: Code bits 22, 23 and 31 are 1 in every code, except that they are 0 when system damage (bit 0) or instruction processing damage (bit 1) is in the code.
- R7: System damage sets bit 0 and instruction processing damage sets bit 1. Both are accepted regardless of `psw_mck_i` and `submask_i`.
- R8: An event pulsed at clock edge k becomes pending at edge k. If it is enabled, `take_o` is a one-cycle pulse at edge k+1, together with the code. All enabled pending conditions are merged into that one code, and masked ones stay pending for a later code.
- R9: A synchronous reset `rst` clears all pending conditions, `take_o` and `code_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sys_dmg_i | input | 1 | System damage event |
| proc_dmg_i | input | 1 | Instruction processing damage event |
| tmr_err_i | input | 1 | CPU timer error event |
| cmp_err_i | input | 1 | Clock comparator error event |
| tf_store_fault_i | input | 1 | Store of a faulty timing facility |
| pwr_warn_i | input | 1 | Power warning event |
| stg_unc_i | input | 1 | Uncorrected storage error report |
| stg_cor_i | input | 1 | Corrected storage error report |
| key_err_i | input | 1 | Protection key error report |
| stg_addr_i | input | AW | Failing address with a storage report |
| psw_mck_i | input | 1 | PSW machine check mask bit |
| submask_i | input | CR_W | Control register submasks |
| tmr_ok_i | input | 1 | CPU timer snapshot captured correctly |
| cmp_ok_i | input | 1 | Clock comparator snapshot captured correctly |
| snap_tmr_o | output | 1 | CPU timer snapshot strobe |
| snap_cmp_o | output | 1 | Clock comparator snapshot strobe |
| take_o | output | 1 | Interruption taken pulse |
| code_o | output | 64 | Interruption code, bit n at index 63-n |
| fail_addr_o | output | AW | Captured failing storage address |

## Verification
The assertions assume that event inputs are single-cycle pulses. They also assume that the mask and submask inputs and the snapshot-valid inputs change only between clock edges, so that an acceptance seen in one cycle is taken at the next edge. The stimulus drives every input on the falling edge and pulses each event for exactly one cycle. It sweeps the PSW mask and all eight combinations of the three used submask bits against each of the nine event sources. Masked cases are released later by opening the masks, which shows that the condition was held.

// File: rtl/mck_pkg.sv
package mck_pkg;
    localparam int NCOND  = 7;
    localparam int CODE_W = 64;

    // pending condition slots
    localparam int CI_SD  = 0;
    localparam int CI_PD  = 1;
    localparam int CI_TD  = 2;
    localparam int CI_WN  = 3;
    localparam int CI_SEU = 4;
    localparam int CI_SEC = 5;
    localparam int CI_KEY = 6;

    // code bit n lives at vector index CODE_W-1-n
    localparam int P_SD   = CODE_W - 1 - 0;
    localparam int P_PD   = CODE_W - 1 - 1;
    localparam int P_SR   = CODE_W - 1 - 2;
    localparam int P_TD   = CODE_W - 1 - 3;
    localparam int P_WN   = CODE_W - 1 - 7;
    localparam int P_WN2  = CODE_W - 1 - 8;
    localparam int P_SEU  = CODE_W - 1 - 16;
    localparam int P_SEC  = CODE_W - 1 - 17;
    localparam int P_KEY  = CODE_W - 1 - 18;
    localparam int P_PMV  = CODE_W - 1 - 22;
    localparam int P_IAV  = CODE_W - 1 - 23;
    localparam int P_FAV  = CODE_W - 1 - 24;
    localparam int P_STV  = CODE_W - 1 - 31;
    localparam int P_TMV  = CODE_W - 1 - 46;
    localparam int P_CMV  = CODE_W - 1 - 47;

    typedef logic [NCOND-1:0] cond_t;
endpackage

// File: rtl/mck_pending.sv
module mck_pending
    import mck_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  cond_t         set_i,
    input  cond_t         clr_i,
    input  logic          stg_ev_i,
    input  logic [AW-1:0] addr_i,
    output cond_t         pend_o,
    output logic [AW-1:0] addr_o
);
    typedef struct packed {
        cond_t         pend;
        logic [AW-1:0] addr;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.pend = (s_q.pend & ~clr_i) | set_i;
        if (stg_ev_i) begin
            s_d.addr = addr_i;
        end
        if (rst) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign pend_o = s_q.pend;
    assign addr_o = s_q.addr;

    // R9: reset empties the pending set
    a_r9_reset_clears: assert property (@(posedge clk) rst |=> (s_q.pend == '0));

    // R1 / R8: a pending bit not accepted is never lost
    a_r8_held_until_taken: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((s_q.pend & $past(s_q.pend & ~clr_i)) == $past(s_q.pend & ~clr_i)));

    // R8: only pending conditions are accepted
    a_r8_accept_subset: assert property (@(posedge clk) disable iff (rst)
        ((clr_i & ~s_q.pend) == '0));
endmodule

// File: rtl/mck_gate.sv
module mck_gate
    import mck_pkg::*;
#(
    parameter int CR_W     = 16,
    parameter int SUB_WARN = 7,
    parameter int SUB_TFD  = 6,
    parameter int SUB_REC  = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  cond_t           pend_i,
    input  logic            psw_i,
    input  logic [CR_W-1:0] sub_i,
    output cond_t           acc_o
);
    cond_t en;

    always_comb begin
        en         = '0;
        en[CI_SD]  = 1'b1;
        en[CI_PD]  = 1'b1;
        en[CI_TD]  = psw_i & sub_i[SUB_TFD];
        en[CI_WN]  = psw_i & sub_i[SUB_WARN];
        en[CI_SEU] = psw_i & sub_i[SUB_REC];
        en[CI_SEC] = psw_i & sub_i[SUB_REC];
        en[CI_KEY] = psw_i & sub_i[SUB_REC];
        acc_o      = pend_i & en;
    end

    // R1: a warning is never accepted with either mask level off
    a_r1_warn_two_level: assert property (@(posedge clk) disable iff (rst)
        (pend_i[CI_WN] && !(psw_i && sub_i[SUB_WARN])) |-> !acc_o[CI_WN]);

    // R7: exigent damage is accepted as soon as it is pending
    a_r7_exigent: assert property (@(posedge clk) disable iff (rst)
        (pend_i[CI_SD] || pend_i[CI_PD]) |-> (acc_o != '0));
endmodule

// File: rtl/mck_code.sv
module mck_code
    import mck_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cond_t             acc_i,
    input  logic              tmr_ok_i,
    input  logic              cmp_ok_i,
    output logic              take_o,
    output logic [CODE_W-1:0] code_o
);
    typedef struct packed {
        logic              take;
        logic [CODE_W-1:0] code;
    } st_t;

    st_t s_d, s_q;
    logic stg, dmg;
    logic [CODE_W-1:0] word;

    always_comb begin
        stg  = acc_i[CI_SEU] | acc_i[CI_SEC] | acc_i[CI_KEY];
        dmg  = acc_i[CI_SD] | acc_i[CI_PD];
        word = '0;
        word[P_SD]  = acc_i[CI_SD];
        word[P_PD]  = acc_i[CI_PD];
        word[P_SR]  = stg;
        word[P_TD]  = acc_i[CI_TD];
        word[P_WN]  = acc_i[CI_WN];
        word[P_WN2] = acc_i[CI_WN];
        word[P_SEU] = acc_i[CI_SEU];
        word[P_SEC] = acc_i[CI_SEC];
        word[P_KEY] = acc_i[CI_KEY];
        word[P_FAV] = stg;
        word[P_PMV] = ~dmg;
        word[P_IAV] = ~dmg;
        word[P_STV] = ~dmg;
        word[P_TMV] = tmr_ok_i;
        word[P_CMV] = cmp_ok_i;

        s_d      = s_q;
        s_d.take = |acc_i;
        if (|acc_i) begin
            s_d.code = word;
        end
        if (rst) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign take_o = s_q.take;
    assign code_o = s_q.code;

    // R6: damage codes carry no PSW / storage validity
    a_r6_damage_clears_valid: assert property (@(posedge clk) disable iff (rst)
        (s_q.take && (s_q.code[P_SD] || s_q.code[P_PD])) |->
        (!s_q.code[P_PMV] && !s_q.code[P_IAV] && !s_q.code[P_STV]));

    // R8: every taken code names at least one interruption type
    a_r8_type_present: assert property (@(posedge clk) disable iff (rst)
        s_q.take |-> ($countones({s_q.code[P_SD], s_q.code[P_PD], s_q.code[P_SR],
                                  s_q.code[P_TD], s_q.code[P_WN]}) > 0));
endmodule

// File: rtl/mck_intr_ctrl.sv
module mck_intr_ctrl
    import mck_pkg::*;
#(
    parameter int AW       = 24,
    parameter int CR_W     = 16,
    parameter int SUB_WARN = 7,
    parameter int SUB_TFD  = 6,
    parameter int SUB_REC  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sys_dmg_i,
    input  logic              proc_dmg_i,
    input  logic              tmr_err_i,
    input  logic              cmp_err_i,
    input  logic              tf_store_fault_i,
    input  logic              pwr_warn_i,
    input  logic              stg_unc_i,
    input  logic              stg_cor_i,
    input  logic              key_err_i,
    input  logic [AW-1:0]     stg_addr_i,
    input  logic              psw_mck_i,
    input  logic [CR_W-1:0]   submask_i,
    input  logic              tmr_ok_i,
    input  logic              cmp_ok_i,
    output logic              snap_tmr_o,
    output logic              snap_cmp_o,
    output logic              take_o,
    output logic [CODE_W-1:0] code_o,
    output logic [AW-1:0]     fail_addr_o
);
    cond_t set_v, pend, acc;
    logic  stg_ev;

    always_comb begin
        set_v         = '0;
        set_v[CI_SD]  = sys_dmg_i;
        set_v[CI_PD]  = proc_dmg_i;
        set_v[CI_TD]  = tmr_err_i | cmp_err_i | tf_store_fault_i;
        set_v[CI_WN]  = pwr_warn_i;
        set_v[CI_SEU] = stg_unc_i;
        set_v[CI_SEC] = stg_cor_i;
        set_v[CI_KEY] = key_err_i;
        stg_ev        = stg_unc_i | stg_cor_i | key_err_i;
    end

    mck_pending #(.AW(AW)) u_pend (
        .clk(clk), .rst(rst), .set_i(set_v), .clr_i(acc),
        .stg_ev_i(stg_ev), .addr_i(stg_addr_i),
        .pend_o(pend), .addr_o(fail_addr_o)
    );

    mck_gate #(.CR_W(CR_W), .SUB_WARN(SUB_WARN), .SUB_TFD(SUB_TFD), .SUB_REC(SUB_REC)) u_gate (
        .clk(clk), .rst(rst), .pend_i(pend), .psw_i(psw_mck_i),
        .sub_i(submask_i), .acc_o(acc)
    );

    mck_code u_code (
        .clk(clk), .rst(rst), .acc_i(acc), .tmr_ok_i(tmr_ok_i),
        .cmp_ok_i(cmp_ok_i), .take_o(take_o), .code_o(code_o)
    );

    assign snap_tmr_o = |acc;
    assign snap_cmp_o = |acc;

    // R4: a snapshot strobe is followed by the taken pulse
    a_r4_snap_then_take: assert property (@(posedge clk) disable iff (rst)
        snap_tmr_o |=> take_o);

    // R4: validity bits follow the snapshot status of the strobe cycle
    a_r4_valid_bits: assert property (@(posedge clk) disable iff (rst)
        snap_cmp_o |=> (code_o[P_TMV] == $past(tmr_ok_i) && code_o[P_CMV] == $past(cmp_ok_i)));
endmodule

// File: tb/mck_intr_ctrl_test.sv
`timescale 1ns/1ps
module mck_intr_ctrl_test;
    localparam int AW = 24;
    localparam int CR_W = 16;

    logic clk = 1'b0;
    logic rst;
    logic sys_dmg, proc_dmg, tmr_err, cmp_err, tfs, pwr_warn, s_unc, s_cor, k_err;
    logic [AW-1:0] s_addr;
    logic psw;
    logic [CR_W-1:0] sub;
    logic tok, cok;
    logic snap_t, snap_c, take;
    logic [63:0] code;
    logic [AW-1:0] faddr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mck_intr_ctrl uut (
        .clk(clk), .rst(rst), .sys_dmg_i(sys_dmg), .proc_dmg_i(proc_dmg),
        .tmr_err_i(tmr_err), .cmp_err_i(cmp_err), .tf_store_fault_i(tfs),
        .pwr_warn_i(pwr_warn), .stg_unc_i(s_unc), .stg_cor_i(s_cor), .key_err_i(k_err),
        .stg_addr_i(s_addr), .psw_mck_i(psw), .submask_i(sub), .tmr_ok_i(tok),
        .cmp_ok_i(cok), .snap_tmr_o(snap_t), .snap_cmp_o(snap_c), .take_o(take),
        .code_o(code), .fail_addr_o(faddr)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // stimulus index: 0 SD, 1 PD, 2 tmr, 3 cmp, 4 tfs, 5 warn, 6 unc, 7 cor, 8 key
    task automatic drive(input logic [8:0] ev);
        sys_dmg = ev[0]; proc_dmg = ev[1]; tmr_err = ev[2]; cmp_err = ev[3];
        tfs = ev[4]; pwr_warn = ev[5]; s_unc = ev[6]; s_cor = ev[7]; k_err = ev[8];
    endtask

    function automatic logic [CR_W-1:0] mk_sub(input logic [2:0] m);
        logic [CR_W-1:0] s;
        s = '0;
        s[7] = m[0]; s[6] = m[1]; s[4] = m[2];
        return s;
    endfunction

    function automatic bit enabled(input int k, input bit p, input logic [2:0] m);
        if (k <= 1) return 1'b1;
        if (k <= 4) return p & m[1];
        if (k == 5) return p & m[0];
        return p & m[2];
    endfunction

    function automatic logic [63:0] cb(input int n);
        return 64'd1 << (63 - n);
    endfunction

    function automatic logic [63:0] exp_code(input logic [8:0] ev, input bit t, input bit c);
        logic [63:0] r;
        bit st, dm;
        r = '0;
        st = ev[6] | ev[7] | ev[8];
        dm = ev[0] | ev[1];
        if (ev[0]) r |= cb(0);
        if (ev[1]) r |= cb(1);
        if (st) r |= cb(2) | cb(24);
        if (ev[2] | ev[3] | ev[4]) r |= cb(3);
        if (ev[5]) r |= cb(7) | cb(8);
        if (ev[6]) r |= cb(16);
        if (ev[7]) r |= cb(17);
        if (ev[8]) r |= cb(18);
        if (!dm) r |= cb(22) | cb(23) | cb(31);
        if (t) r |= cb(46);
        if (c) r |= cb(47);
        return r;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; drive('0); s_addr = '0; psw = 0; sub = '0; tok = 0; cok = 0;
        repeat (3) @(negedge clk);
        chk("R9 reset take", {63'd0, take}, 64'd0);
        chk("R9 reset code", code, 64'd0);
        chk("R9 reset snap", {63'd0, snap_t}, 64'd0);
        rst = 1'b0;
        @(negedge clk);

        // sweep: mask, submasks, source
        for (int p = 0; p < 2; p++) begin
            for (int m = 0; m < 8; m++) begin
                for (int k = 0; k < 9; k++) begin
                    logic [8:0] ev;
                    bit en, t, c;
                    logic [AW-1:0] a;
                    ev = 9'd1 << k;
                    en = enabled(k, p[0], m[2:0]);
                    t = m[0] ^ k[0];
                    c = p[0] ^ m[1];
                    a = AW'(24'h0F0000 + p * 1000 + m * 16 + k);
                    psw = p[0]; sub = mk_sub(m[2:0]); tok = t; cok = c;
                    s_addr = a;
                    drive(ev);
                    @(negedge clk);
                    drive('0);
                    chk($sformatf("R4 snap p%0d m%0d k%0d", p, m, k), {63'd0, snap_t & snap_c}, {63'd0, en});
                    @(negedge clk);
                    chk($sformatf("R8 take p%0d m%0d k%0d", p, m, k), {63'd0, take}, {63'd0, en});
                    if (en) begin
                        chk($sformatf("R2 R3 R5 R6 R7 code p%0d m%0d k%0d", p, m, k), code, exp_code(ev, t, c));
                        if (k >= 6) chk("R5 fail addr", {40'd0, faddr}, {40'd0, a});
                        @(negedge clk);
                        chk("R8 take one cycle", {63'd0, take}, 64'd0);
                    end else begin
                        @(negedge clk);
                        chk($sformatf("R1 R3 R5 held p%0d m%0d k%0d", p, m, k), {63'd0, take | snap_t}, 64'd0);
                        psw = 1; sub = mk_sub(3'b111);
                        #1;
                        chk("R1 R8 release snap", {63'd0, snap_t}, 64'd1);
                        @(negedge clk);
                        chk($sformatf("R1 R8 release code p%0d m%0d k%0d", p, m, k), code, exp_code(ev, t, c));
                        chk("R1 release take", {63'd0, take}, 64'd1);
                    end
                    psw = 0; sub = '0;
                    @(negedge clk);
                end
            end
        end

        // R8: merge of several enabled sources in one code
        psw = 1; sub = mk_sub(3'b111); tok = 1; cok = 0; s_addr = 24'h123456;
        drive(9'b010100100);
        @(negedge clk); drive('0);
        @(negedge clk);
        chk("R8 merged code", code, exp_code(9'b010100100, 1, 0));
        chk("R5 merged addr", {40'd0, faddr}, {40'd0, 24'h123456});

        // R8 / R6: damage taken while warning stays masked, then warning alone
        psw = 0; sub = '0; tok = 0; cok = 1;
        drive(9'b000100001);
        @(negedge clk); drive('0);
        @(negedge clk);
        chk("R7 R6 damage only", code, exp_code(9'b000000001, 0, 1));
        @(negedge clk);
        chk("R1 warn still held", {63'd0, take}, 64'd0);
        psw = 1; sub = mk_sub(3'b001);
        @(negedge clk);
        chk("R2 warn later", code, exp_code(9'b000100000, 0, 1));

        // R9: reset discards a masked pending warning
        psw = 0; sub = '0;
        drive(9'b000100000);
        @(negedge clk); drive('0);
        rst = 1;
        @(negedge clk);
        rst = 0;
        chk("R9 code cleared", code, 64'd0);
        psw = 1; sub = mk_sub(3'b111);
        @(negedge clk);
        @(negedge clk);
        chk("R9 nothing left", {63'd0, take}, 64'd0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule